// File: doc/BRIEF.md
# Compare Timer with Write-Blocked Match

A 16-bit up-counter driven by a selectable prescaler, paired with one 16-bit compare register and an equality comparator. When the counter equals the compare value on a timer tick, a sticky interrupt flag is raised. In clear-on-match mode the counter returns to zero one clock after the matching tick, so the count runs from zero up to the compare value plus one.

Software reaches the block over an 8-bit register bus. A byte-wide holding latch between the bus and the 16-bit registers keeps 16-bit accesses coherent: high byte first on writes, low byte first on reads. Any write to the counter arms a one-shot suppression that swallows the comparison on the next timer tick. This applies whether the counter is running or stopped. Software can therefore load the counter with the compare value and start the timer without raising a spurious interrupt.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, the compare register, the control register and the flag are all zero, and `irq_o` is low.
- R2: The control register sits at address 0. Bits 2:0 select the clock and bit 3 enables clear-on-match. Bits 7:4 read as zero and writes to them have no effect.
- R3: Clock-select code 1 ticks every clock. Codes 2, 3 and 4 tick every 8, 64 and 256 clocks. Codes 0, 5, 6 and 7 stop the timer. While stopped, the prescaler is held at zero, so the first tick comes N clocks after the select takes effect.
- R4: Address map: counter low/high bytes at 2/3, compare low/high bytes at 4/5.
  - A high-byte write only loads the holding latch. The following low-byte write commits both bytes in one cycle.
  - Reading the counter low byte copies the counter high byte into the latch, and reading address 3 returns the latch.
  - Address 5 reads the compare high byte directly.
- R5: On each tick the counter increments by one, wrapping from 0xFFFF to 0x0000.
- R6: On a tick where the counter equals the compare value, the flag (bit 0 at address 1) is set, and `irq_o` follows the flag.
- R7: A counter write suppresses the comparison on the next tick only, whether the timer was running or stopped when written.
- R8: If the written counter value equals the compare value, that match is lost and the flag stays clear.
- R9: With clear-on-match enabled, the counter shows compare+1 for one clock after the matching tick and is zero on the clock after that.
- R10: Writing 1 to flag bit 0 clears the flag. A match in the same cycle keeps it set.
- R11: A counter write takes priority over both a pending clear-on-match and a tick increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (needed for the low-byte latch side effect) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Compare-match flag |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a counter write and a compare match. The bench lands counter writes on the tick that would have matched, both while the timer is stopped and while it runs at full rate. It also writes during the clock in which a clear-on-match is pending. The final counter value and flag then show which action won.

The second pair is a software flag clear and a hardware flag set. The bench times a write-1 clear to land on the matching tick while the flag is already set, and judges it by reading the flag back afterwards.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_FLAG   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_CMP_LO = 3'd4,
    A_CMP_HI = 3'd5
  } reg_addr_e;

  typedef enum logic [SEL_W-1:0] {
    CS_STOP   = 3'd0,
    CS_DIV1   = 3'd1,
    CS_DIV8   = 3'd2,
    CS_DIV64  = 3'd3,
    CS_DIV256 = 3'd4
  } clk_sel_e;
endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc
  import cmp_timer_pkg::*;
#(
  parameter int LOG_B = 3,
  parameter int LOG_C = 6,
  parameter int LOG_D = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = LOG_D;

  logic [PRE_W-1:0] pre_q, mask;
  logic             run;

  always_comb begin
    run  = 1'b1;
    mask = '0;
    case (sel_i)
      CS_DIV1:   mask = '0;
      CS_DIV8:   mask = PRE_W'((32'd1 << LOG_B) - 32'd1);
      CS_DIV64:  mask = PRE_W'((32'd1 << LOG_C) - 32'd1);
      CS_DIV256: mask = PRE_W'((32'd1 << LOG_D) - 32'd1);
      default:   run  = 1'b0;
    endcase
  end

  assign tick_o = run && ((pre_q & mask) == mask);

  // prescaler phase restarts whenever the timer is stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
    else          pre_q <= '0;
  end
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              ctc_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              flag_clr_o
);
  localparam int HI_W   = CNT_W - BUS_W;
  localparam int CTRL_W = SEL_W + 1;

  logic [HI_W-1:0]   tmp_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp_q;

  assign sel_o       = ctrl_q[SEL_W-1:0];
  assign ctc_o       = ctrl_q[SEL_W];
  assign cmp_o       = cmp_q;
  assign cnt_wr_o    = wr_i && (addr_i == A_CNT_LO);
  assign cnt_wdata_o = {tmp_q, wdata_i};
  assign flag_clr_o  = wr_i && (addr_i == A_FLAG) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o = BUS_W'(ctrl_q);
      A_FLAG:   rdata_o = BUS_W'(flag_i);
      A_CNT_LO: rdata_o = cnt_i[BUS_W-1:0];
      A_CNT_HI: rdata_o = BUS_W'(tmp_q);
      A_CMP_LO: rdata_o = cmp_q[BUS_W-1:0];
      A_CMP_HI: rdata_o = BUS_W'(cmp_q[CNT_W-1:BUS_W]);
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q  <= '0;
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (rd_i && addr_i == A_CNT_LO) tmp_q <= cnt_i[CNT_W-1:BUS_W];
      if (wr_i) begin
        case (addr_i)
          A_CTRL:             ctrl_q <= wdata_i[CTRL_W-1:0];
          A_CNT_HI, A_CMP_HI: tmp_q  <= wdata_i[HI_W-1:0];
          A_CMP_LO:           cmp_q  <= {tmp_q, wdata_i};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctc_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             match_o,
  output logic             blk_o,
  output logic             clr_pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             blk_q, pend_q, flag_q;

  assign match_o    = tick_i && !blk_q && !cnt_wr_i && (cnt_q == cmp_i);
  assign cnt_o      = cnt_q;
  assign flag_o     = flag_q;
  assign blk_o      = blk_q;
  assign clr_pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      blk_q  <= 1'b0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_wr_i)    cnt_q <= cnt_wdata_i;
      else if (pend_q) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;

      // one-shot: armed by a counter write, consumed by the next tick
      if (cnt_wr_i)    blk_q <= 1'b1;
      else if (tick_i) blk_q <= 1'b0;

      pend_q <= match_o && ctc_i;

      if (match_o)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int LOG_B = 3,
  parameter int LOG_C = 6,
  parameter int LOG_D = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [SEL_W-1:0] sel;
  logic             ctc, tick, cnt_wr, flag_clr, flag, match, blk, clr_pend;
  logic [CNT_W-1:0] cmp, cnt, cnt_wdata;

  cmp_timer_presc #(.LOG_B(LOG_B), .LOG_C(LOG_C), .LOG_D(LOG_D)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel),
    .tick_o(tick)
  );

  cmp_timer_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_i      (cnt),
    .flag_i     (flag),
    .sel_o      (sel),
    .ctc_o      (ctc),
    .cmp_o      (cmp),
    .cnt_wr_o   (cnt_wr),
    .cnt_wdata_o(cnt_wdata),
    .flag_clr_o (flag_clr)
  );

  cmp_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .ctc_i      (ctc),
    .cmp_i      (cmp),
    .cnt_wr_i   (cnt_wr),
    .cnt_wdata_i(cnt_wdata),
    .flag_clr_i (flag_clr),
    .cnt_o      (cnt),
    .flag_o     (flag),
    .match_o    (match),
    .blk_o      (blk),
    .clr_pend_o (clr_pend)
  );

  assign irq_o = flag;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  rdata_i,
  input logic              tick_i,
  input logic              blk_i,
  input logic              match_i,
  input logic              cnt_wr_i,
  input logic              clr_pend_i,
  input logic              ctc_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              flag_i
);
  // R2
  ctrl_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> (rdata_i[BUS_W-1:4] == '0));

  // R3
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr_i && !clr_pend_i) |=> $stable(cnt_i));

  // R5
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && !clr_pend_i) |=> (cnt_i == $past(cnt_i) + 1'b1));

  // R7
  blocked_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && blk_i && !flag_i) |=> !flag_i);

  // R9
  late_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && ctc_i) ##1 !cnt_wr_i |=> (cnt_i == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_i);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rdata_i   (rdata_o),
  .tick_i    (tick),
  .blk_i     (blk),
  .match_i   (match),
  .cnt_wr_i  (cnt_wr),
  .clr_pend_i(clr_pend),
  .ctc_i     (ctc),
  .cnt_i     (cnt),
  .flag_i    (flag)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  import cmp_timer_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  cmp_timer uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1 wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i); #1 rd_i = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(A_CNT_HI, v[15:8]); wr(A_CNT_LO, v[7:0]);
  endtask

  task automatic set_cmp(input logic [15:0] v);
    wr(A_CMP_HI, v[15:8]); wr(A_CMP_LO, v[7:0]);
  endtask

  task automatic get_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(A_CNT_LO, lo); rd(A_CNT_HI, hi);
    v = {hi, lo};
  endtask

  task automatic get_flag(output logic f);
    logic [7:0] d;
    rd(A_FLAG, d);
    f = d[0];
  endtask

  // run for k clocks with the given control value, then stop
  task automatic run(input logic [7:0] ctl, input int k);
    wr(A_CTRL, ctl);
    if (k > 1) repeat (k - 1) @(posedge clk_i);
    wr(A_CTRL, 8'h00);
    repeat (2) @(posedge clk_i);
  endtask

  function automatic int div_of(input int sel);
    case (sel)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      default: return 0;
    endcase
  endfunction

  // reference: k clocks after a counter write, ticks every n clocks
  task automatic model(input logic [15:0] c0, input logic [15:0] cmp, input int n,
                       input bit ctc, input int k,
                       output logic [15:0] cnt, output bit flag);
    bit blk, pend, m, t;
    blk = 1'b1; pend = 1'b0; cnt = c0; flag = 1'b0;
    for (int j = 0; j < k; j++) begin
      t = (n > 0) && ((j % n) == n - 1);
      m = t && !blk && (cnt == cmp);
      if (m) flag = 1'b1;
      if (t) blk = 1'b0;
      if (pend)   cnt = '0;
      else if (t) cnt = cnt + 16'd1;
      pend = m && ctc;
    end
    if (pend) cnt = '0;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0]  d;
    logic [15:0] v, exp_cnt;
    logic        f;
    bit          exp_flag;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq", irq_o, 0);
    rd(A_CTRL, d);   chk("R1 ctrl", d, 0);
    get_flag(f);     chk("R1 flag", f, 0);
    get_cnt(v);      chk("R1 cnt", v, 0);
    rd(A_CMP_LO, d); chk("R1 cmp lo", d, 0);
    rd(A_CMP_HI, d); chk("R1 cmp hi", d, 0);

    // R2 reserved bits, R3 invalid code stopped
    set_cnt(16'h0777);
    wr(A_CTRL, 8'hF8);
    rd(A_CTRL, d); chk("R2 ctrl F8", d, 8'h08);
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, d); chk("R2 ctrl FF", d, 8'h0F);
    repeat (20) @(posedge clk_i);
    wr(A_CTRL, 8'h00);
    get_cnt(v); chk("R3 code 7 stopped", v, 16'h0777);

    // R4 atomic write / read-back of compare
    set_cnt(16'h1111);
    wr(A_CNT_HI, 8'h22);
    get_cnt(v); chk("R4 high byte alone", v, 16'h1111);
    wr(A_CNT_HI, 8'h22); wr(A_CNT_LO, 8'h33);
    get_cnt(v); chk("R4 commit", v, 16'h2233);
    set_cmp(16'hA55A);
    rd(A_CMP_LO, d); chk("R4 cmp lo", d, 8'h5A);
    rd(A_CMP_HI, d); chk("R4 cmp hi", d, 8'hA5);

    // R4 low read latches the high byte while counting
    set_cmp(16'h8000);
    set_cnt(16'h01FE);
    wr(A_CTRL, 8'h01);
    rd(A_CNT_LO, d); chk("R4 running lo", d, 8'hFE);
    repeat (4) @(posedge clk_i);
    rd(A_CNT_HI, d); chk("R4 latched hi", d, 8'h01);
    wr(A_CTRL, 8'h00);
    repeat (2) @(posedge clk_i);
    get_cnt(v); chk("R4 running total", v, 16'h0205);

    // R5 wraparound
    set_cnt(16'hFFFE);
    run(8'h01, 5);
    get_cnt(v); chk("R5 wrap", v, 16'h0003);

    // R7 R8 stopped write equal to compare is lost
    wr(A_FLAG, 8'h01);
    set_cmp(16'h0040);
    set_cnt(16'h0040);
    run(8'h01, 3);
    get_flag(f); chk("R8 stopped equal lost", f, 0);
    get_cnt(v);  chk("R7 stopped cnt", v, 16'h0043);

    // R7 block lasts one tick only; R6 match sets flag
    set_cnt(16'h003F);
    run(8'h01, 1);
    get_flag(f); chk("R7 blocked tick", f, 0);
    run(8'h01, 2);
    get_flag(f); chk("R6 match after block spent", f, 1);
    chk("R6 irq", irq_o, 1);

    // R7 running write equal to compare
    wr(A_FLAG, 8'h01);
    set_cmp(16'h1234);
    set_cnt(16'h0100);
    wr(A_CTRL, 8'h01);
    repeat (2) @(posedge clk_i);
    set_cnt(16'h1234);
    repeat (2) @(posedge clk_i);
    wr(A_CTRL, 8'h00);
    repeat (2) @(posedge clk_i);
    get_flag(f); chk("R7 running equal blocked", f, 0);
    get_cnt(v);  chk("R7 running cnt", v, 16'h1237);

    // R7 running write one below compare still matches
    set_cnt(16'h0100);
    wr(A_CTRL, 8'h01);
    repeat (2) @(posedge clk_i);
    set_cnt(16'h1233);
    repeat (2) @(posedge clk_i);
    wr(A_CTRL, 8'h00);
    repeat (2) @(posedge clk_i);
    get_flag(f); chk("R7 running next value matches", f, 1);
    get_cnt(v);  chk("R7 running cnt 2", v, 16'h1236);

    // R9 one-clock-late clear
    set_cmp(16'h0010);
    set_cnt(16'h000E);
    wr(A_CTRL, 8'h09);
    repeat (3) @(posedge clk_i);
    rd(A_CNT_LO, d); chk("R9 cmp+1 visible", d, 8'h11);
    rd(A_CNT_LO, d); chk("R9 cleared next clock", d, 8'h00);
    rd(A_CNT_LO, d); chk("R9 counts from zero", d, 8'h01);
    wr(A_CTRL, 8'h00);
    repeat (2) @(posedge clk_i);

    // R10 set wins over clear (flag already 1)
    set_cmp(16'h0200);
    set_cnt(16'h01FE);
    wr(A_CTRL, 8'h01);
    repeat (2) @(posedge clk_i);
    wr(A_FLAG, 8'h01);
    wr(A_CTRL, 8'h00);
    get_flag(f); chk("R10 set wins", f, 1);
    wr(A_FLAG, 8'h00);
    get_flag(f); chk("R10 write 0 no effect", f, 1);
    wr(A_FLAG, 8'h01);
    get_flag(f); chk("R10 clear", f, 0);
    chk("R10 irq low", irq_o, 0);

    // R11 counter write over pending clear
    set_cmp(16'h0020);
    set_cnt(16'h001E);
    wr(A_CTRL, 8'h09);
    repeat (2) @(posedge clk_i);
    wr(A_CNT_HI, 8'h05);
    wr(A_CNT_LO, 8'h00);
    repeat (1) @(posedge clk_i);
    wr(A_CTRL, 8'h00);
    repeat (2) @(posedge clk_i);
    get_cnt(v); chk("R11 write beats pending clear", v, 16'h0502);

    // R3 R5 R6 R8 R9 sweep over clock selects, modes and offsets
    for (int sel = 0; sel < 8; sel++) begin
      for (int ctc = 0; ctc < 2; ctc++) begin
        for (int b = 0; b < 2; b++) begin
          for (int di = 0; di < 3; di++) begin
            logic [15:0] c0, cmpv;
            int n, k;
            n    = div_of(sel);
            k    = (n > 0) ? n * 8 + 3 : 11;
            c0   = (b == 0) ? 16'h0100 : 16'hFFFD;
            cmpv = c0 + 16'((di == 0) ? 0 : (di == 1) ? 2 : 5);
            wr(A_FLAG, 8'h01);
            set_cmp(cmpv);
            set_cnt(c0);
            run({4'b0, 1'(ctc), 3'(sel)}, k);
            model(c0, cmpv, n, 1'(ctc), k, exp_cnt, exp_flag);
            get_cnt(v);  chk($sformatf("R3 R5 R9 sweep cnt sel%0d ctc%0d b%0d d%0d", sel, ctc, b, di), v, exp_cnt);
            get_flag(f); chk($sformatf("R6 R8 sweep flag sel%0d ctc%0d b%0d d%0d", sel, ctc, b, di), f, exp_flag);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule